// File: doc/BRIEF.md
# Data Memory Address Generator

This block computes the data-space address used by load and store operations in a small 8-bit processor core. A single flat data space holds the register file at addresses 0x00 to 0x1F, then I/O memory, extended I/O and SRAM. The generator accepts an addressing-mode code, a pointer-pair selector, the 16-bit value currently held in the selected pointer pair, a 6-bit displacement, a 6-bit I/O location and a 16-bit direct address. From these it produces the effective address, the new value for the pointer pair, and a strobe that tells the register file to store that value.

The instruction decoder asserts `go` for one cycle with the operand fields. The results are registered, so they appear on the outputs one clock later, qualified by `ea_valid`. The pointer-updating forms change the pointer. Those forms are decrement-before-access, which uses the decremented value as the address, and increment-after-access, which uses the old value. The displacement form adds an unsigned offset to the pointer and does not change the pointer. The direct forms take the address from the instruction fields.

Top module: `dmag`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `ea`, `wb_data`, `wb_en`, `bad_mode` and `ea_valid` are all zero.
- R2: Mode code 0 (I/O direct) gives `ea` = `io_addr` + 0x20 with `wb_en` low. The selector is ignored, including value 3.
- R3: Mode code 1 (data direct) gives `ea` = `direct_addr` with `wb_en` low. The selector is ignored.
- R4: Mode code 2 (displacement), with selector 1 (Y) or 2 (Z), gives `ea` = (`ptr_val` + zero-extended `disp`) mod 2^16, with `wb_en` low and `wb_data` = `ptr_val`.
- R5: Mode code 2 with selector 0 (X) sets `bad_mode`, holds `wb_en` low and drives `ea` to 0.
- R6: Mode code 3 (post-increment) with selector 0, 1 or 2 gives `ea` = `ptr_val`, `wb_data` = (`ptr_val` + 1) mod 2^16 and `wb_en` high. 0xFFFF wraps to 0x0000.
- R7: Mode code 4 (pre-decrement) with selector 0, 1 or 2 gives `wb_data` = (`ptr_val` − 1) mod 2^16, `ea` equal to that same value, and `wb_en` high. 0x0000 wraps to 0xFFFF.
- R8: Each result appears on the clock after the one that samples `go`, and `ea_valid` is high for exactly that one cycle. In a cycle that follows a low `go`, `wb_en` and `ea_valid` are low and `ea`, `wb_data` and `bad_mode` keep their values.
- R9: Mode codes 5 to 7, and selector 3 in modes 2 to 4, set `bad_mode`, hold `wb_en` low, drive `ea` to 0 and give `wb_data` = `ptr_val`. In the I/O-direct and data-direct modes, `wb_data` = `ptr_val` as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Operand fields are valid this cycle |
| mode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer pair: 0 X, 1 Y, 2 Z |
| ptr_val | input | 16 | Current value of the selected pointer pair |
| disp | input | 6 | Unsigned displacement |
| io_addr | input | 6 | I/O location |
| direct_addr | input | 16 | Direct data address |
| ea | output | 16 | Effective data-space address |
| wb_data | output | 16 | Value to write back into the pointer pair |
| wb_en | output | 1 | Pointer write-back strobe |
| bad_mode | output | 1 | Illegal mode and selector combination |
| ea_valid | output | 1 | Outputs carry a new result |

## Verification
The assertions assume that every input is a known value on each clock edge where `go` is high. They also assume that `ptr_val` is the pointer value the decoder intends to use for that operation. The bench changes inputs only on falling edges, so the fields are stable across the sampling edge. It covers the legal and illegal combinations of mode and selector directly, then a long run of random fields and random gaps in `go`. The random run includes every mode code 0 to 7 and every selector 0 to 3. The directed cases include the pointer values 0x0000 and 0xFFFF and a displacement that crosses the 16-bit wrap.

// File: rtl/dmag.sv
module dmag #(
  parameter int AW     = 16,
  parameter int QW     = 6,
  parameter int IOW    = 6,
  parameter int IO_OFS = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [2:0]    mode,
  input  logic [1:0]    ptr_sel,
  input  logic [AW-1:0] ptr_val,
  input  logic [QW-1:0] disp,
  input  logic [IOW-1:0] io_addr,
  input  logic [AW-1:0] direct_addr,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] wb_data,
  output logic          wb_en,
  output logic          bad_mode,
  output logic          ea_valid
);
  localparam logic [2:0] M_IO   = 3'd0;
  localparam logic [2:0] M_DIR  = 3'd1;
  localparam logic [2:0] M_DISP = 3'd2;
  localparam logic [2:0] M_POST = 3'd3;
  localparam logic [2:0] M_PRE  = 3'd4;
  localparam logic [1:0] SEL_X  = 2'd0;
  localparam logic [1:0] SEL_NONE = 2'd3;

  logic          uses_ptr, bad;
  logic [AW-1:0] ptr_inc, ptr_dec, ptr_off, io_ea;
  logic [AW-1:0] nxt_ea, nxt_wb;
  logic          nxt_wen;

  assign uses_ptr = (mode == M_DISP) || (mode == M_POST) || (mode == M_PRE);
  assign bad      = (mode > M_PRE)
                  || (uses_ptr && ptr_sel == SEL_NONE)
                  || (mode == M_DISP && ptr_sel == SEL_X);

  assign ptr_inc = ptr_val + AW'(1);
  assign ptr_dec = ptr_val - AW'(1);
  assign ptr_off = ptr_val + AW'(disp);
  assign io_ea   = AW'(io_addr) + AW'(IO_OFS);

  always_comb begin
    nxt_ea  = '0;
    nxt_wb  = ptr_val;
    nxt_wen = 1'b0;
    if (!bad) begin
      case (mode)
        M_IO:   nxt_ea = io_ea;
        M_DIR:  nxt_ea = direct_addr;
        M_DISP: nxt_ea = ptr_off;
        M_POST: begin
          nxt_ea  = ptr_val;
          nxt_wb  = ptr_inc;
          nxt_wen = 1'b1;
        end
        M_PRE: begin
          nxt_ea  = ptr_dec;
          nxt_wb  = ptr_dec;
          nxt_wen = 1'b1;
        end
        default: nxt_ea = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea       <= '0;
      wb_data  <= '0;
      wb_en    <= 1'b0;
      bad_mode <= 1'b0;
      ea_valid <= 1'b0;
    end else begin
      ea_valid <= go;
      wb_en    <= go && nxt_wen;
      if (go) begin
        ea       <= nxt_ea;
        wb_data  <= nxt_wb;
        bad_mode <= bad;
      end
    end
  end
endmodule

// File: rtl/dmag_chk.sv
module dmag_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic [2:0]    mode,
  input logic [1:0]    ptr_sel,
  input logic [AW-1:0] ptr_val,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] wb_data,
  input logic          wb_en,
  input logic          bad_mode,
  input logic          ea_valid
);
  // R8
  valid_follows_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> ea_valid);

  // R8
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> (!ea_valid && !wb_en && $stable(ea) && $stable(wb_data)));

  // R5
  bad_blocks_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_mode |-> (!wb_en && ea == '0));

  // R6
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == 3'd3 && ptr_sel != 2'd3) |=> (wb_en && wb_data == ea + AW'(1)));

  // R7
  pre_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && mode == 3'd4 && ptr_sel != 2'd3) |=> (wb_en && wb_data == ea && ea == $past(ptr_val) - AW'(1)));

  // R9
  wb_only_when_moving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && (mode < 3'd3 || mode > 3'd4)) |=> !wb_en);
endmodule

bind dmag dmag_chk #(.AW(AW)) u_chk (.*);

// File: tb/dmag_tb.sv
module dmag_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  ptr_sel = '0;
  logic [15:0] ptr_val = '0;
  logic [5:0]  disp = '0;
  logic [5:0]  io_addr = '0;
  logic [15:0] direct_addr = '0;
  logic [15:0] ea, wb_data;
  logic        wb_en, bad_mode, ea_valid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int e_ea = 0, e_wb = 0;
  bit e_wen = 0, e_bad = 0, e_val = 0;

  always #10 clk = ~clk;

  dmag u_dut (
    .clk(clk), .rst_n(rst_n), .go(go), .mode(mode), .ptr_sel(ptr_sel),
    .ptr_val(ptr_val), .disp(disp), .io_addr(io_addr), .direct_addr(direct_addr),
    .ea(ea), .wb_data(wb_data), .wb_en(wb_en), .bad_mode(bad_mode), .ea_valid(ea_valid)
  );

  function automatic string req_of(bit g, int m, int s);
    if (!g) return "R8";
    if (m > 4 || (m >= 2 && s == 3)) return "R9";
    case (m)
      0: return "R2";
      1: return "R3";
      2: return (s == 0) ? "R5" : "R4";
      3: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic model(bit g, int m, int s, int p, int q, int io, int da);
    e_val = g;
    e_wen = 0;
    if (!g) return;
    e_bad = (m > 4) || (m >= 2 && s == 3) || (m == 2 && s == 0);
    e_wb  = p;
    e_ea  = 0;
    if (!e_bad) begin
      if (m == 0) e_ea = io + 32;
      else if (m == 1) e_ea = da;
      else if (m == 2) e_ea = (p + q) % 65536;
      else if (m == 3) begin e_ea = p; e_wb = (p + 1) % 65536; e_wen = 1; end
      else begin e_ea = (p + 65535) % 65536; e_wb = e_ea; e_wen = 1; end
    end
  endtask

  task automatic compare(string rq);
    n_chk++;
    if (ea !== 16'(e_ea) || wb_data !== 16'(e_wb) || wb_en !== e_wen ||
        bad_mode !== e_bad || ea_valid !== e_val) begin
      n_fail++;
      $display("FAIL %s: got ea=%h wb=%h wen=%b bad=%b val=%b, expected ea=%h wb=%h wen=%b bad=%b val=%b",
               rq, ea, wb_data, wb_en, bad_mode, ea_valid,
               16'(e_ea), 16'(e_wb), e_wen, e_bad, e_val);
    end
  endtask

  task automatic step(bit g, int m, int s, int p, int q = 0, int io = 0, int da = 0);
    go = g; mode = 3'(m); ptr_sel = 2'(s); ptr_val = 16'(p);
    disp = 6'(q); io_addr = 6'(io); direct_addr = 16'(da);
    @(posedge clk);
    model(g, m, s, p, q, io, da);
    @(negedge clk);
    compare(req_of(g, m, s));
  endtask

  initial begin
    @(negedge clk);
    compare("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare("R1");
    step(1, 0, 0, 16'h1234, 0, 6'h3F);
    step(1, 0, 3, 0, 0, 6'h00);
    step(1, 1, 2, 0, 0, 0, 16'hBEEF);
    step(1, 2, 1, 16'h0100, 6'h3F);
    step(1, 2, 2, 16'hFFF0, 6'h20);
    step(1, 2, 0, 16'h0100, 6'h05);
    step(1, 3, 0, 16'h00FF);
    step(1, 3, 2, 16'hFFFF);
    step(1, 4, 1, 16'h0000);
    step(1, 4, 2, 16'h8000);
    step(0, 4, 2, 16'h7777);
    step(0, 1, 0, 16'h1111, 0, 0, 16'h2222);
    step(1, 5, 1, 16'h4444);
    step(1, 7, 0, 16'h5555);
    step(1, 3, 3, 16'h6666);
    step(1, 2, 3, 16'h6666, 6'h01);
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, $urandom % 8, $urandom % 4, $urandom % 65536,
           $urandom % 64, $urandom % 64, $urandom % 65536);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule